// File: doc/BRIEF.md
# Display RAM write-address counter

This block keeps the write pointer for a display memory of 102 columns by 9 banks, where each bank holds one 8-pixel byte per column. The column coordinate X runs from 0 to 101, and its value is the number of the column output that the byte lands on. The bank coordinate Y runs from 0 to 8. A command decoder elsewhere loads X and Y on separate strobes and sets the scan order. The memory path pulses `step` once after each display byte is written.

In horizontal order, X moves first and carries into Y. In vertical order, Y moves first and carries into X. The last cell (X=101, Y=8) always wraps to (0, 0). Load values outside the legal ranges are saturated to the top legal value. As a result, no sequence of loads and steps can leave the pointer outside the memory.

The current X, Y and a flat byte address Y*102+X are available as plain outputs. No data flows through the block, so it has no valid/ready interface.

Top module: `disp_addr_counter`

## Requirements
- R1: After reset, X=0 and Y=0, and the scan order is horizontal, so the first step after reset gives X=1, Y=0.
- R2: A cycle with `x_load`=1 stores `x_value` into X when `x_value`<=101, and stores 101 otherwise; X never exceeds 101; Y is left unchanged.
- R3: A cycle with `y_load`=1 stores `y_value` into Y when `y_value`<=8, and stores 8 otherwise; Y never exceeds 8; X is left unchanged.
- R4: In horizontal order, a step gives X+1 with Y unchanged; from X=101 it gives X=0 and Y+1.
- R5: In vertical order, a step gives Y+1 with X unchanged; from Y=8 it gives Y=0 and X+1.
- R6: From X=101, Y=8, a step gives X=0, Y=0 in either order.
- R7: A step in a cycle that also has `x_load` or `y_load` is ignored, and only the loads take effect.
- R8: A cycle with `mode_load`=1 stores the scan order from `mode_vert` (0 = horizontal, 1 = vertical); a step in that same cycle still follows the previous order.
- R9: `flat_addr` always equals Y*102+X for the X and Y currently presented on the outputs.
- R10: Outputs change only on the clock edge that ends a cycle with a load or step; a cycle with none of these leaves X and Y unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_load | input | 1 | Load strobe for the column coordinate |
| x_value | input | 7 | Column value to load (saturated to 101) |
| y_load | input | 1 | Load strobe for the bank coordinate |
| y_value | input | 4 | Bank value to load (saturated to 8) |
| mode_load | input | 1 | Load strobe for the scan order |
| mode_vert | input | 1 | Scan order to load: 1 = vertical, 0 = horizontal |
| step | input | 1 | One pulse per written display byte |
| cur_x | output | 7 | Current column coordinate |
| cur_y | output | 4 | Current bank coordinate |
| flat_addr | output | 10 | Flat byte address Y*102+X |

## Verification
Every load, step and mode change takes effect at the first rising edge after the cycle that presents it. `flat_addr` follows X and Y in that same edge, with no extra register. The driver holds each stimulus for exactly one cycle and pushes the model's expected X and Y into a queue shortly after that edge. The monitor pops and compares each entry at the next falling edge, so every comparison falls on the first sampling point after the result is due. The stimulus includes both wrap boundaries in each order, the last-cell wrap, and a full horizontal sweep of all 918 cells.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int DEF_COLS  = 102;
  localparam int DEF_BANKS = 9;

  typedef enum logic {
    SCAN_HORIZ = 1'b0,
    SCAN_VERT  = 1'b1
  } scan_e;
endpackage

// File: rtl/dac_wrap_counter.sv
// Saturating-load, wrapping counter over 0 .. LIMIT-1.
module dac_wrap_counter #(
  parameter int LIMIT = 102,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         adv,
  output logic [W-1:0] val,
  output logic         at_last
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] ld_sat;

  assign at_last = (val == LAST);
  assign ld_sat  = (ld_val > LAST) ? LAST : ld_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (ld) begin
      val <= ld_sat;
    end else if (adv) begin
      val <= at_last ? '0 : val + W'(1);
    end
  end
endmodule

// File: rtl/dac_addr_flatten.sv
// Row-major byte address: bank * COLS + column.
module dac_addr_flatten #(
  parameter int COLS  = 102,
  parameter int BANKS = 9,
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(BANKS),
  parameter int AW    = $clog2(COLS * BANKS)
) (
  input  logic [XW-1:0] col,
  input  logic [YW-1:0] bank,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STRIDE = AW'(COLS);

  always_comb begin
    addr = AW'(bank) * STRIDE + AW'(col);
  end
endmodule

// File: rtl/disp_addr_counter.sv
module disp_addr_counter #(
  parameter int COLS  = dac_pkg::DEF_COLS,
  parameter int BANKS = dac_pkg::DEF_BANKS,
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(BANKS),
  parameter int AW    = $clog2(COLS * BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_load,
  input  logic [XW-1:0] x_value,
  input  logic          y_load,
  input  logic [YW-1:0] y_value,
  input  logic          mode_load,
  input  logic          mode_vert,
  input  logic          step,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic [AW-1:0] flat_addr
);
  import dac_pkg::*;

  scan_e scan_q;
  logic  step_ok;
  logic  x_last, y_last;
  logic  x_adv, y_adv;

  // Scan order register; a step in the same cycle sees the old order.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= SCAN_HORIZ;
    end else if (mode_load) begin
      scan_q <= scan_e'(mode_vert);
    end
  end

  // Loads win over a step arriving in the same cycle.
  assign step_ok = step & ~x_load & ~y_load;

  // The leading coordinate always moves; the other moves on carry.
  assign x_adv = step_ok & ((scan_q == SCAN_HORIZ) | y_last);
  assign y_adv = step_ok & ((scan_q == SCAN_VERT)  | x_last);

  dac_wrap_counter #(.LIMIT(COLS), .W(XW)) u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (x_load),
    .ld_val  (x_value),
    .adv     (x_adv),
    .val     (cur_x),
    .at_last (x_last)
  );

  dac_wrap_counter #(.LIMIT(BANKS), .W(YW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (y_load),
    .ld_val  (y_value),
    .adv     (y_adv),
    .val     (cur_y),
    .at_last (y_last)
  );

  dac_addr_flatten #(
    .COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW), .AW(AW)
  ) u_flat (
    .col  (cur_x),
    .bank (cur_y),
    .addr (flat_addr)
  );
endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
  parameter int COLS  = 102,
  parameter int BANKS = 9,
  parameter int XW    = $clog2(COLS),
  parameter int YW    = $clog2(BANKS),
  parameter int AW    = $clog2(COLS * BANKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          x_load,
  input logic [XW-1:0] x_value,
  input logic          y_load,
  input logic [YW-1:0] y_value,
  input logic          step,
  input logic          vert,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [AW-1:0] flat_addr
);
  localparam logic [XW-1:0] XL = XW'(COLS - 1);
  localparam logic [YW-1:0] YL = YW'(BANKS - 1);

  logic stp;
  assign stp = step & ~x_load & ~y_load;

  p_x_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_x <= XL);

  p_y_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_y <= YL);

  p_x_load_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    x_load |=> cur_x == (($past(x_value) > XL) ? XL : $past(x_value)));

  p_y_load_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    y_load |=> cur_y == (($past(y_value) > YL) ? YL : $past(y_value)));

  p_h_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && !vert && cur_x != XL) |=>
      (cur_x == $past(cur_x) + XW'(1)) && $stable(cur_y));

  p_v_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && vert && cur_y != YL) |=>
      (cur_y == $past(cur_y) + YW'(1)) && $stable(cur_x));

  p_corner_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && cur_x == XL && cur_y == YL) |=> (cur_x == '0 && cur_y == '0));

  p_flat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flat_addr == AW'(cur_y) * AW'(COLS) + AW'(cur_x));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_load && !y_load && !step) |=> ($stable(cur_x) && $stable(cur_y)));
endmodule

bind disp_addr_counter dac_checker #(
  .COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .x_load    (x_load),
  .x_value   (x_value),
  .y_load    (y_load),
  .y_value   (y_value),
  .step      (step),
  .vert      (scan_q == dac_pkg::SCAN_VERT),
  .cur_x     (cur_x),
  .cur_y     (cur_y),
  .flat_addr (flat_addr)
);

// File: tb/disp_addr_counter_tb_top.sv
`timescale 1ns/1ps
module disp_addr_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x_load = 1'b0, y_load = 1'b0, mode_load = 1'b0;
  logic       mode_vert = 1'b0, step = 1'b0;
  logic [6:0] x_value = '0;
  logic [3:0] y_value = '0;
  logic [6:0] cur_x;
  logic [3:0] cur_y;
  logic [9:0] flat_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    x;
    int    y;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // model state
  int mx = 0, my = 0, mv = 0;

  always #10 clk = ~clk;  // 50 MHz

  disp_addr_counter dut_i (
    .clk(clk), .rst_n(rst_n),
    .x_load(x_load), .x_value(x_value),
    .y_load(y_load), .y_value(y_value),
    .mode_load(mode_load), .mode_vert(mode_vert),
    .step(step),
    .cur_x(cur_x), .cur_y(cur_y), .flat_addr(flat_addr)
  );

  task automatic check_now(input int ex, input int ey, input string tag);
    n_run++;
    if (cur_x !== 7'(ex) || cur_y !== 4'(ey) || flat_addr !== 10'(ey * 102 + ex)) begin
      n_fail++;
      $display("FAIL %s: got x=%0d y=%0d flat=%0d, expected x=%0d y=%0d flat=%0d",
               tag, cur_x, cur_y, flat_addr, ex, ey, ey * 102 + ex);
    end
  endtask

  // Driver: one-cycle stimulus, model update, push expected after the edge.
  task automatic op(input bit xl, input int xv, input bit yl, input int yv,
                    input bit ml, input bit mvi, input bit st, input string tag);
    exp_t e;
    @(negedge clk);
    x_load = xl; x_value = 7'(xv);
    y_load = yl; y_value = 4'(yv);
    mode_load = ml; mode_vert = mvi; step = st;
    if (xl) mx = (xv > 101) ? 101 : xv;
    if (yl) my = (yv > 8) ? 8 : yv;
    if (st && !xl && !yl) begin
      if (mv == 0) begin
        if (mx == 101) begin mx = 0; my = (my == 8) ? 0 : my + 1; end
        else mx = mx + 1;
      end else begin
        if (my == 8) begin my = 0; mx = (mx == 101) ? 0 : mx + 1; end
        else my = my + 1;
      end
    end
    if (ml) mv = mvi;
    @(posedge clk);
    #2;
    e.x = mx; e.y = my; e.tag = tag;
    sb_q.push_back(e);
    x_load = 0; y_load = 0; mode_load = 0; step = 0;
  endtask

  // Monitor: compare at the falling edge after each result is due.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_now(e.x, e.y, e.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(0, 0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_now(0, 0, "R1 after release");

    op(0, 0, 0, 0, 0, 0, 1, "R1 first step horizontal");
    op(0, 0, 0, 0, 0, 0, 0, "R10 idle hold");
    op(1, 57, 0, 0, 0, 0, 0, "R2 load x");
    op(1, 120, 0, 0, 0, 0, 0, "R2 load x saturate");
    op(0, 0, 1, 5, 0, 0, 0, "R3 load y");
    op(0, 0, 1, 15, 0, 0, 0, "R3 load y saturate");
    op(1, 99, 1, 2, 0, 0, 0, "R2 R3 load both");
    op(0, 0, 0, 0, 0, 0, 1, "R4 horiz step");
    op(0, 0, 0, 0, 0, 0, 1, "R4 horiz step to 101");
    op(0, 0, 0, 0, 0, 0, 1, "R4 horiz carry into y");
    op(1, 10, 0, 0, 0, 0, 1, "R7 step with x load");
    op(0, 0, 1, 7, 0, 0, 1, "R7 step with y load");
    op(0, 0, 0, 0, 1, 1, 1, "R8 mode load uses old order");
    op(0, 0, 0, 0, 0, 0, 1, "R5 vert step");
    op(0, 0, 0, 0, 0, 0, 1, "R5 vert carry into x");
    op(0, 0, 0, 0, 0, 0, 1, "R5 vert step after carry");
    op(1, 101, 1, 8, 0, 0, 0, "R6 set last cell");
    op(0, 0, 0, 0, 0, 0, 1, "R6 corner wrap vertical");
    op(1, 101, 1, 8, 1, 0, 0, "R6 last cell, back to horizontal");
    op(0, 0, 0, 0, 0, 0, 1, "R6 corner wrap horizontal");
    op(1, 100, 1, 8, 0, 0, 0, "R4 set x=100 y=8");
    op(0, 0, 0, 0, 0, 0, 1, "R4 step to 101 on last bank");
    op(0, 0, 0, 0, 0, 0, 0, "R10 idle hold 2");
    op(0, 0, 0, 0, 1, 1, 0, "R8 mode only, no move");
    op(1, 101, 1, 3, 0, 0, 0, "R5 set x=101 y=3");
    op(0, 0, 0, 0, 0, 0, 1, "R5 vert step at x=101");
    op(0, 0, 1, 8, 0, 0, 1, "R7 y load beats step");
    op(0, 0, 0, 0, 0, 0, 1, "R6 vert wrap from 101/8");
    op(0, 0, 0, 0, 1, 0, 0, "R8 back to horizontal");
    for (int i = 0; i < 918; i++) op(0, 0, 0, 0, 0, 0, 1, "R9 full horizontal sweep");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule